// File: doc/BRIEF.md
# Character Display Host Bus Interface

This block is the register port that a host processor sees on a character display controller. The host drives an enable strobe, a register-select line, a read/write line and an 8-bit data bus. The block brings those pins into the system clock domain through a synchronizer chain. It acts on the falling edge of the enable strobe. Completed writes go either to the instruction register, which feeds the command decoder, or to the data register, which feeds display memory. Reads return either a status byte or the data register. The status byte carries the busy flag in its top bit and the 7-bit address counter below it.

The bus works 8 bits at a time or 4 bits at a time. In the narrow mode only the upper four data lines carry information, and each byte takes two enable pulses. The execution core tells the block which mode to use through a mode-load strobe. The core also supplies the busy flag and the address counter. It preloads the data register from display memory, so a data read returns its byte at once. Each finished data read is reported back to the core so that it can advance the address and fetch the next byte. The data lines are driven only during a read pulse, and only while the interface is enabled.

Top module: `lcd_host_if`

## Requirements
- R1: A completed cycle with select=0 and direction=0 (write) while `core_busy` is 0 loads the byte into `ir_q` and raises `ir_wr_valid` for exactly one clock cycle.
- R2: A completed instruction write while `core_busy` is 1 is dropped. `ir_wr_valid` stays low and `ir_q` keeps its previous value.
- R3: A read with select=0 returns the status byte. Bit 7 is `core_busy` and bits 6..0 are `core_ac`. Nothing is written and no strobe is produced.
- R4: A `core_fill` pulse loads `core_rdata` into the data register. A read with select=1 returns that byte, and completing the read pulses `dr_rd_done` once.
- R5: A completed write with select=1 loads the byte into `dr_q` and raises `dr_wr_valid` for one cycle. A following data read returns that byte.
- R6: A transfer takes effect only after the enable strobe falls. No strobe appears while enable is still high.
- R7: In 4-bit mode a write needs two enable pulses. The first carries bits 7..4 of the byte on data lines 7..4, and the second carries bits 3..0 on the same lines. Lines 3..0 are ignored, and the first pulse alone produces no strobe.
- R8: In 4-bit mode a read puts the upper nibble of the byte on data lines 7..4 during the first pulse and the lower nibble during the second. Lines 3..0 are driven to 0.
- R9: `bus_d_oe` is 1 only while enable is high, direction is read (1) and `if_en` is 1. Otherwise the bus is released.
- R10: Reset selects 8-bit mode, clears the nibble phase, releases the bus and clears both registers and all strobes.
- R11: A `mode_wr` pulse clears the nibble phase. The next 4-bit pulse is then taken as an upper nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Permits the block to drive the data bus |
| bus_e | input | 1 | Host enable strobe (asynchronous) |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | Direction: 0 write, 1 read |
| bus_d_in | input | 8 | Data bus as seen at the pads |
| bus_d_out | output | 8 | Value driven onto the data bus |
| bus_d_oe | output | 1 | Output enable for the data bus pads |
| core_busy | input | 1 | Busy flag from the execution core |
| core_ac | input | 7 | Address counter from the execution core |
| core_fill | input | 1 | Strobe that loads `core_rdata` into the data register |
| core_rdata | input | 8 | Prefetched display memory byte |
| mode_wr | input | 1 | Strobe that loads the bus width |
| mode_4bit | input | 1 | Width loaded by `mode_wr`: 1 = 4-bit, 0 = 8-bit |
| ir_q | output | 8 | Instruction register |
| ir_wr_valid | output | 1 | One-cycle pulse: new instruction accepted |
| dr_q | output | 8 | Data register |
| dr_wr_valid | output | 1 | One-cycle pulse: host wrote the data register |
| dr_rd_done | output | 1 | One-cycle pulse: host finished a data read |

## Verification
The bench tries an instruction write while busy. A block that ignored the busy flag would emit an unexpected instruction strobe and overwrite the register. In 4-bit mode it drives junk on the low data lines and splits the byte across two pulses. A design that used the low lines, or swapped the nibble order, would assemble a different byte. It also confirms that a lone first nibble produces nothing. The bench leaves a half-finished nibble pair behind and then reloads the mode, so a design that failed to clear the phase would pair the old upper nibble with the new data. Reads are checked with the interface disabled, where a design that ignored the enable would drive the bus. Status reads are checked in both widths, where a wrong bit order would put the busy flag or the address counter in the wrong lanes.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;

  // Encoding follows {select, direction} of the host cycle.
  typedef enum logic [1:0] {
    XF_IR_WR = 2'b00,
    XF_SR_RD = 2'b01,
    XF_DR_WR = 2'b10,
    XF_DR_RD = 2'b11
  } xfer_kind_e;

  function automatic xfer_kind_e kind_of(input logic sel, input logic dir);
    return xfer_kind_e'({sel, dir});
  endfunction

endpackage

// File: rtl/lcdh_sync.sv
module lcdh_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lcdh_xfer.sv
module lcdh_xfer
  import lcdh_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_s,
  input  logic              rs_s,
  input  logic              rw_s,
  input  logic [DATA_W-1:0] d_s,
  input  logic              mode_wr,
  input  logic              mode_4bit,
  output logic              mode4,
  output logic              phase,
  output logic              done,
  output xfer_kind_e        done_kind,
  output logic [DATA_W-1:0] done_byte
);

  logic              e_q;
  logic              rs_q;
  logic              rw_q;
  logic [DATA_W-1:0] d_q;
  logic [NIB_W-1:0]  hi_nib;
  logic              fall;

  // Values held while enable was still high, one cycle before the fall is seen.
  always_ff @(posedge clk) begin
    if (rst) begin
      e_q  <= 1'b0;
      rs_q <= 1'b0;
      rw_q <= 1'b0;
      d_q  <= '0;
    end else begin
      e_q  <= e_s;
      rs_q <= rs_s;
      rw_q <= rw_s;
      d_q  <= d_s;
    end
  end

  assign fall = e_q & ~e_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode4     <= 1'b0;
      phase     <= 1'b0;
      hi_nib    <= '0;
      done      <= 1'b0;
      done_kind <= XF_IR_WR;
      done_byte <= '0;
    end else begin
      done <= 1'b0;
      if (mode_wr) begin
        mode4 <= mode_4bit;
        phase <= 1'b0;
      end else if (fall) begin
        if (!mode4) begin
          done      <= 1'b1;
          done_kind <= kind_of(rs_q, rw_q);
          done_byte <= d_q;
        end else if (!phase) begin
          phase  <= 1'b1;
          hi_nib <= d_q[DATA_W-1 -: NIB_W];
        end else begin
          phase     <= 1'b0;
          done      <= 1'b1;
          done_kind <= kind_of(rs_q, rw_q);
          done_byte <= {hi_nib, d_q[DATA_W-1 -: NIB_W]};
        end
      end
    end
  end

endmodule

// File: rtl/lcdh_regs.sv
module lcdh_regs
  import lcdh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  xfer_kind_e        done_kind,
  input  logic [DATA_W-1:0] done_byte,
  input  logic              core_busy,
  input  logic              core_fill,
  input  logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] ir_q,
  output logic              ir_wr_valid,
  output logic [DATA_W-1:0] dr_q,
  output logic              dr_wr_valid,
  output logic              dr_rd_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q        <= '0;
      dr_q        <= '0;
      ir_wr_valid <= 1'b0;
      dr_wr_valid <= 1'b0;
      dr_rd_done  <= 1'b0;
    end else begin
      ir_wr_valid <= 1'b0;
      dr_wr_valid <= 1'b0;
      dr_rd_done  <= 1'b0;
      if (core_fill) dr_q <= core_rdata;
      if (done) begin
        unique case (done_kind)
          XF_IR_WR: begin
            if (!core_busy) begin
              ir_q        <= done_byte;
              ir_wr_valid <= 1'b1;
            end
          end
          XF_DR_WR: begin
            dr_q        <= done_byte;
            dr_wr_valid <= 1'b1;
          end
          XF_DR_RD: dr_rd_done <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/lcdh_rdmux.sv
module lcdh_rdmux #(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2,
  localparam int AC_W  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_s,
  input  logic              rs_s,
  input  logic              rw_s,
  input  logic              if_en,
  input  logic              mode4,
  input  logic              phase,
  input  logic              core_busy,
  input  logic [AC_W-1:0]   core_ac,
  input  logic [DATA_W-1:0] dr_q,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe
);

  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] val;
  logic              drive;

  assign src   = rs_s ? dr_q : {core_busy, core_ac};
  assign drive = e_s & rw_s & if_en;

  always_comb begin
    if (!mode4)      val = src;
    else if (!phase) val = {src[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
    else             val = {held[NIB_W-1:0], {NIB_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      d_out <= '0;
      d_oe  <= 1'b0;
    end else begin
      if (!phase) held <= src;
      d_oe  <= drive;
      d_out <= drive ? val : '0;
    end
  end

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcdh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AC_W       = DATA_W - 1,
  localparam int SYNC_W     = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              if_en,
  input  logic              bus_e,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  input  logic              core_busy,
  input  logic [AC_W-1:0]   core_ac,
  input  logic              core_fill,
  input  logic [DATA_W-1:0] core_rdata,
  input  logic              mode_wr,
  input  logic              mode_4bit,
  output logic [DATA_W-1:0] ir_q,
  output logic              ir_wr_valid,
  output logic [DATA_W-1:0] dr_q,
  output logic              dr_wr_valid,
  output logic              dr_rd_done
);

  logic [SYNC_W-1:0] pins_s;
  logic              e_s;
  logic              rs_s;
  logic              rw_s;
  logic [DATA_W-1:0] d_s;
  logic              mode4_w;
  logic              phase_w;
  logic              done_w;
  xfer_kind_e        kind_w;
  logic [DATA_W-1:0] byte_w;

  lcdh_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_e, bus_rs, bus_rw, bus_d_in}),
    .q   (pins_s)
  );

  assign {e_s, rs_s, rw_s, d_s} = pins_s;

  lcdh_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .e_s       (e_s),
    .rs_s      (rs_s),
    .rw_s      (rw_s),
    .d_s       (d_s),
    .mode_wr   (mode_wr),
    .mode_4bit (mode_4bit),
    .mode4     (mode4_w),
    .phase     (phase_w),
    .done      (done_w),
    .done_kind (kind_w),
    .done_byte (byte_w)
  );

  lcdh_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .done        (done_w),
    .done_kind   (kind_w),
    .done_byte   (byte_w),
    .core_busy   (core_busy),
    .core_fill   (core_fill),
    .core_rdata  (core_rdata),
    .ir_q        (ir_q),
    .ir_wr_valid (ir_wr_valid),
    .dr_q        (dr_q),
    .dr_wr_valid (dr_wr_valid),
    .dr_rd_done  (dr_rd_done)
  );

  lcdh_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .e_s       (e_s),
    .rs_s      (rs_s),
    .rw_s      (rw_s),
    .if_en     (if_en),
    .mode4     (mode4_w),
    .phase     (phase_w),
    .core_busy (core_busy),
    .core_ac   (core_ac),
    .dr_q      (dr_q),
    .d_out     (bus_d_out),
    .d_oe      (bus_d_oe)
  );

endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              if_en,
  input logic              core_busy,
  input logic              bus_d_oe,
  input logic [DATA_W-1:0] bus_d_out,
  input logic [DATA_W-1:0] ir_q,
  input logic              ir_wr_valid,
  input logic              dr_wr_valid,
  input logic              dr_rd_done,
  input logic              mode4
);

  // R2: an accepted instruction never follows a busy cycle
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    ir_wr_valid |-> !$past(core_busy));

  // R2: the instruction register only moves together with its strobe
  p_ir_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !ir_wr_valid |-> $stable(ir_q));

  // R6: one completed transfer gives one single-cycle strobe
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (ir_wr_valid || dr_wr_valid || dr_rd_done) |=>
      !(ir_wr_valid || dr_wr_valid || dr_rd_done));

  // R9: the bus is driven only when the interface was enabled
  p_oe_gated_r9: assert property (@(posedge clk) disable iff (rst)
    bus_d_oe |-> $past(if_en));

  // R8: low data lines carry zero in narrow mode
  p_low_lines_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_d_oe && mode4) |-> (bus_d_out[NIB_W-1:0] == '0));

  // R10: reset leaves the bus released in wide mode
  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (!bus_d_oe && !mode4 && !ir_wr_valid));

endmodule

bind lcd_host_if lcd_host_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .if_en       (if_en),
  .core_busy   (core_busy),
  .bus_d_oe    (bus_d_oe),
  .bus_d_out   (bus_d_out),
  .ir_q        (ir_q),
  .ir_wr_valid (ir_wr_valid),
  .dr_wr_valid (dr_wr_valid),
  .dr_rd_done  (dr_rd_done),
  .mode4       (mode4_w)
);

// File: tb/lcd_host_if_bench.sv
module lcd_host_if_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       if_en = 1'b1;
  logic       bus_e = 1'b0;
  logic       bus_rs = 1'b0;
  logic       bus_rw = 1'b0;
  logic [7:0] bus_d_in = '0;
  logic [7:0] bus_d_out;
  logic       bus_d_oe;
  logic       core_busy = 1'b0;
  logic [6:0] core_ac = '0;
  logic       core_fill = 1'b0;
  logic [7:0] core_rdata = '0;
  logic       mode_wr = 1'b0;
  logic       mode_4bit = 1'b0;
  logic [7:0] ir_q;
  logic       ir_wr_valid;
  logic [7:0] dr_q;
  logic       dr_wr_valid;
  logic       dr_rd_done;

  int n_checks = 0;
  int n_errors = 0;
  int n_strobe = 0;
  int exp_rdone = 0;
  bit finished = 1'b0;
  logic [7:0] q_ir[$];
  logic [7:0] q_dw[$];

  always #4 clk = ~clk;

  lcd_host_if u_lcd_host_if (
    .clk (clk), .rst (rst), .if_en (if_en),
    .bus_e (bus_e), .bus_rs (bus_rs), .bus_rw (bus_rw),
    .bus_d_in (bus_d_in), .bus_d_out (bus_d_out), .bus_d_oe (bus_d_oe),
    .core_busy (core_busy), .core_ac (core_ac),
    .core_fill (core_fill), .core_rdata (core_rdata),
    .mode_wr (mode_wr), .mode_4bit (mode_4bit),
    .ir_q (ir_q), .ir_wr_valid (ir_wr_valid),
    .dr_q (dr_q), .dr_wr_valid (dr_wr_valid), .dr_rd_done (dr_rd_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected results as strobes appear
  always @(negedge clk) begin
    if (!rst) begin
      if (ir_wr_valid) begin
        n_strobe++;
        if (q_ir.size() == 0) chk(1'b0, "R2 unexpected instruction", ir_q, 0);
        else begin
          logic [7:0] e;
          e = q_ir.pop_front();
          chk(ir_q == e, "R1 instruction byte", ir_q, e);
        end
      end
      if (dr_wr_valid) begin
        n_strobe++;
        if (q_dw.size() == 0) chk(1'b0, "R5 unexpected data write", dr_q, 0);
        else begin
          logic [7:0] e;
          e = q_dw.pop_front();
          chk(dr_q == e, "R5 data byte", dr_q, e);
        end
      end
      if (dr_rd_done) begin
        n_strobe++;
        chk(exp_rdone > 0, "R4 unexpected read completion", 1, 0);
        if (exp_rdone > 0) exp_rdone--;
      end
    end
  end

  // One enable pulse; samples the bus while enable is high
  task automatic pulse(input logic rs, input logic rw, input logic [7:0] d,
                       output logic [7:0] seen_d, output logic seen_oe);
    int n0;
    bus_rs = rs; bus_rw = rw; bus_d_in = d;
    repeat (2) @(negedge clk);
    n0 = n_strobe;
    bus_e = 1'b1;
    repeat (6) @(negedge clk);
    seen_d = bus_d_out; seen_oe = bus_d_oe;
    repeat (2) @(negedge clk);
    chk(n_strobe == n0, "R6 strobe before fall", n_strobe, n0);
    bus_e = 1'b0;
    repeat (8) @(negedge clk);
    chk(bus_d_oe == 1'b0, "R9 bus released after cycle", bus_d_oe, 0);
  endtask

  task automatic set_mode(input logic four);
    mode_4bit = four; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] sd;
    logic       so;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(bus_d_oe == 0, "R10 oe", bus_d_oe, 0);
    chk(ir_q == 0 && dr_q == 0, "R10 registers", {ir_q, dr_q}, 0);

    // R1: instruction write, 8-bit
    q_ir.push_back(8'h38);
    pulse(0, 0, 8'h38, sd, so);
    chk(so == 0, "R9 no drive on write", so, 0);
    chk(ir_q == 8'h38, "R1 ir_q", ir_q, 8'h38);

    // R2: write while busy is dropped
    core_busy = 1'b1;
    pulse(0, 0, 8'h01, sd, so);
    chk(ir_q == 8'h38, "R2 ir_q kept", ir_q, 8'h38);

    // R3: status reads
    core_ac = 7'h2A;
    pulse(0, 1, 8'h00, sd, so);
    chk(so == 1 && sd == 8'hAA, "R3 status busy", {so, sd}, 9'h1AA);
    core_busy = 1'b0; core_ac = 7'h7F;
    pulse(0, 1, 8'h00, sd, so);
    chk(sd == 8'h7F, "R3 status idle", sd, 8'h7F);

    // R4: prefetched data read
    core_rdata = 8'hC5; core_fill = 1'b1;
    @(negedge clk);
    core_fill = 1'b0;
    exp_rdone++;
    pulse(1, 1, 8'h00, sd, so);
    chk(sd == 8'hC5, "R4 data read", sd, 8'hC5);

    // R5: data write then read back
    q_dw.push_back(8'h5A);
    pulse(1, 0, 8'h5A, sd, so);
    chk(dr_q == 8'h5A, "R5 dr_q", dr_q, 8'h5A);
    exp_rdone++;
    pulse(1, 1, 8'h00, sd, so);
    chk(sd == 8'h5A, "R5 read back", sd, 8'h5A);

    // R9: interface disabled
    if_en = 1'b0;
    pulse(0, 1, 8'h00, sd, so);
    chk(so == 0, "R9 disabled no drive", so, 0);
    if_en = 1'b1;

    // R7: 4-bit instruction write with junk on low lines
    set_mode(1'b1);
    q_ir.push_back(8'h9C);
    pulse(0, 0, 8'h9F, sd, so);
    chk(ir_q == 8'h38, "R7 no strobe after first nibble", ir_q, 8'h38);
    pulse(0, 0, 8'hC3, sd, so);
    chk(ir_q == 8'h9C, "R7 assembled byte", ir_q, 8'h9C);

    // R8: 4-bit status read
    core_busy = 1'b1; core_ac = 7'h15;
    pulse(0, 1, 8'h0F, sd, so);
    chk(so == 1 && sd == 8'h90, "R8 upper nibble", {so, sd}, 9'h190);
    pulse(0, 1, 8'h0F, sd, so);
    chk(sd == 8'h50, "R8 lower nibble", sd, 8'h50);
    core_busy = 1'b0;

    // R11: mode reload discards a pending upper nibble
    pulse(0, 0, 8'hA0, sd, so);
    set_mode(1'b1);
    q_ir.push_back(8'h42);
    pulse(0, 0, 8'h40, sd, so);
    pulse(0, 0, 8'h20, sd, so);
    chk(ir_q == 8'h42, "R11 fresh pair", ir_q, 8'h42);

    // R10: reset from 4-bit mode returns to 8-bit
    pulse(0, 0, 8'hB0, sd, so);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ir_q == 0, "R10 ir cleared", ir_q, 0);
    q_ir.push_back(8'h0C);
    pulse(0, 0, 8'h0C, sd, so);
    chk(ir_q == 8'h0C, "R10 8-bit after reset", ir_q, 8'h0C);

    repeat (4) @(negedge clk);
    chk(q_ir.size() == 0, "R1 missing instruction strobes", q_ir.size(), 0);
    chk(q_dw.size() == 0, "R5 missing data strobes", q_dw.size(), 0);
    chk(exp_rdone == 0, "R4 missing read completions", exp_rdone, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule